// File: doc/BRIEF.md
# Programmable Up/Down Loop-Filter Counter

This block is the digital loop filter of a first-order all-digital phase-locked loop. It runs on a fast filter clock. On every edge it counts one step up or down, and the direction comes from an exclusive-OR phase detector that compares the reference with the fed-back signal. The detector gives its full lock range only when both inputs have a 50% duty cycle. When the count wraps over its top value, the block raises a carry pulse for one clock. When it wraps under zero, it raises a borrow pulse for one clock. A downstream stage uses these pulses to insert or delete output cycles. The increment/decrement stage and the divide-by-N counter are outside this block.

A 4-bit length code sets the counter length, and through it the loop bandwidth. The code may change while the loop runs. Code 0 turns the counter off. Code 1 gives the shortest counter, which has the widest bandwidth and the fastest lock. Code 15 gives a 17-stage counter, which has the narrowest bandwidth and the slowest lock. When the code changes, the counter trims its count to the new length on the next clock. It makes no step and no pulse on that clock.

Top module: `loop_filter_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `count_o` = 0 and both `carry_o` and `borrow_o` low.
- R2: For a length code c from 1 to 15, the counter has c+2 stages, so its modulus is 2^(c+2). `count_o` never exceeds 2^(c+2)-1. Code 1 gives modulus 8 and code 15 gives modulus 131072.
- R3: While the length code is 0, `count_o` stays 0 and neither pulse is raised.
- R4: The direction is `ref_i` XOR `fb_i`, sampled at the filter-clock edge. A 1 counts down one step and a 0 counts up one step on that edge.
- R5: Counting up from the top value gives 0 on the next clock and raises `carry_o` for exactly that one clock.
- R6: Counting down from 0 gives the top value on the next clock and raises `borrow_o` for exactly that one clock. `carry_o` and `borrow_o` are never high together.
- R7: On the first edge at which the length code differs from the code of the previous edge, the new count is the old count ANDed with the new mask (2^(c+2)-1, or 0 for code 0). That edge makes no step and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Reference signal for the phase detector |
| fb_i | input | 1 | Fed-back signal for the phase detector |
| len_sel | input | 4 | Counter length code (0 turns the counter off) |
| count_o | output | 17 | Current filter count |
| carry_o | output | 1 | One-clock pulse when the count wraps upward |
| borrow_o | output | 1 | One-clock pulse when the count wraps downward |

## Verification
The bench drives the count to the top of a modulus-32 counter and then shortens the counter while the direction is still up. A design that counted on that edge instead of only trimming would wrap and raise a false carry. It checks that both wrap pulses last one clock and fall at the right counts for modulus 8, 128 and 131072. A fixed-width or off-by-one stage decode shows up there as a wrong pulse count or a wrong top value. It also drives all four input combinations of the phase detector, which catches an inverted direction. It toggles the inputs with code 0 selected, which catches a counter that does not turn off fully.

// File: rtl/lf_pkg.sv
package lf_pkg;
   // Mask of active stages for a length code; code 0 disables all stages.
   function automatic logic [31:0] mask_bits(input int code, input int ofs);
      logic [31:0] m;
      m = '0;
      if (code != 0) begin
         for (int b = 0; b < 32; b++) begin
            if (b < code + ofs) m[b] = 1'b1;
         end
      end
      return m;
   endfunction
endpackage

// File: rtl/lf_phase_det.sv
module lf_phase_det #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   input  logic fb_i,
   output logic err_o
);
   logic raw;
   assign raw = ref_i ^ fb_i;

   generate
      if (REG_OUT) begin : g_reg
         logic err_q;
         always_ff @(posedge clk) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= raw;
         end
         assign err_o = err_q;
      end else begin : g_comb
         assign err_o = raw;
      end
   endgenerate
endmodule

// File: rtl/lf_len_dec.sv
module lf_len_dec #(
   parameter int SEL_W = 4,
   parameter int OFS   = 2,
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] mask_o,
   output logic             en_o,
   output logic             chg_o
);
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_i;
   end

   assign en_o  = (sel_i != '0);
   assign chg_o = (sel_i != sel_q);

   genvar b;
   generate
      for (b = 0; b < CNT_W; b++) begin : g_mask
         assign mask_o[b] = en_o && (b < (int'(sel_i) + OFS));
      end
   endgenerate
endmodule

// File: rtl/lf_updn_core.sv
module lf_updn_core #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             chg_i,
   input  logic [CNT_W-1:0] mask_i,
   input  logic             dn_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             carry_o,
   output logic             borrow_o
);
   logic [CNT_W-1:0] cnt_q, cm;
   logic             car_q, bor_q;

   assign cm = cnt_q & mask_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         car_q <= 1'b0;
         bor_q <= 1'b0;
      end else begin
         car_q <= 1'b0;
         bor_q <= 1'b0;
         if (!en_i) begin
            cnt_q <= '0;
         end else if (chg_i) begin
            cnt_q <= cm;
         end else if (dn_i) begin
            if (cm == '0) begin
               cnt_q <= mask_i;
               bor_q <= 1'b1;
            end else begin
               cnt_q <= cm - 1'b1;
            end
         end else begin
            if (cm == mask_i) begin
               cnt_q <= '0;
               car_q <= 1'b1;
            end else begin
               cnt_q <= cm + 1'b1;
            end
         end
      end
   end

   assign cnt_o    = cnt_q;
   assign carry_o  = car_q;
   assign borrow_o = bor_q;
endmodule

// File: rtl/loop_filter_counter.sv
module loop_filter_counter #(
   parameter int SEL_W  = 4,
   parameter int OFS    = 2,
   parameter bit PD_REG = 1'b0,
   localparam int CNT_W = (1 << SEL_W) - 1 + OFS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_i,
   input  logic             fb_i,
   input  logic [SEL_W-1:0] len_sel,
   output logic [CNT_W-1:0] count_o,
   output logic             carry_o,
   output logic             borrow_o
);
   initial begin
      if (SEL_W < 1 || SEL_W > 4) $error("SEL_W must be 1..4");
      if (OFS < 1)                $error("OFS must be at least 1");
      if (CNT_W > 31)             $error("CNT_W must not exceed 31");
   end

   logic             dn;
   logic             en, chg;
   logic [CNT_W-1:0] mask;

   lf_phase_det #(.REG_OUT(PD_REG)) u_pd (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i), .err_o(dn)
   );

   lf_len_dec #(.SEL_W(SEL_W), .OFS(OFS), .CNT_W(CNT_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .sel_i(len_sel),
      .mask_o(mask), .en_o(en), .chg_o(chg)
   );

   lf_updn_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en_i(en), .chg_i(chg), .mask_i(mask),
      .dn_i(dn), .cnt_o(count_o), .carry_o(carry_o), .borrow_o(borrow_o)
   );
endmodule

// File: rtl/lf_chk.sv
module lf_chk #(
   parameter int SEL_W = 4,
   parameter int OFS   = 2,
   parameter int CNT_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] len_sel,
   input logic [CNT_W-1:0] count_o,
   input logic             carry_o,
   input logic             borrow_o
);
   logic [31:0]      pm;
   logic [SEL_W-1:0] prev_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pm       <= '0;
         prev_sel <= '0;
      end else begin
         pm       <= lf_pkg::mask_bits(int'(len_sel), OFS);
         prev_sel <= len_sel;
      end
   end

   p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= pm[CNT_W-1:0]);

   p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (len_sel == '0) |=> (count_o == '0 && !carry_o && !borrow_o));

   p_carry_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |-> (count_o == '0));

   p_carry_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |=> !carry_o);

   p_borrow_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      borrow_o |-> (count_o == pm[CNT_W-1:0] && pm != '0));

   p_borrow_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      borrow_o |=> !borrow_o);

   p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(carry_o && borrow_o));

   p_quiet_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (len_sel != prev_sel) |=> (!carry_o && !borrow_o));
endmodule

bind loop_filter_counter lf_chk #(.SEL_W(SEL_W), .OFS(OFS), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .len_sel(len_sel),
   .count_o(count_o), .carry_o(carry_o), .borrow_o(borrow_o)
);

// File: tb/sim_loop_filter_counter.sv
module sim_loop_filter_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_i = 1'b0, fb_i = 1'b0;
   logic [3:0]  len_sel = 4'd0;
   logic [16:0] count_o;
   logic        carry_o, borrow_o;

   int checks = 0, fails = 0, cycles = 0;
   int mcnt = 0, mcar = 0, mbor = 0, mprev = 0;
   int ncar, nbor;

   always #5 clk = ~clk;

   loop_filter_counter u0 (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i), .len_sel(len_sel),
      .count_o(count_o), .carry_o(carry_o), .borrow_o(borrow_o)
   );

   function automatic int mk(int c);
      return (c == 0) ? 0 : ((1 << (c + 2)) - 1);
   endfunction

   // Behavioural reference, updated on each filter-clock edge
   always @(posedge clk) begin
      int m, c, d;
      m = mk(int'(len_sel));
      c = mcnt & m;
      d = int'(ref_i ^ fb_i);
      mcar = 0; mbor = 0;
      if (!rst_n) begin
         mcnt = 0; mprev = 0;
      end else begin
         if (len_sel == 0)                mcnt = 0;
         else if (int'(len_sel) != mprev) mcnt = c;
         else if (d == 1) begin
            if (c == 0) begin mcnt = m; mbor = 1; end
            else mcnt = c - 1;
         end else begin
            if (c == m) begin mcnt = 0; mcar = 1; end
            else mcnt = c + 1;
         end
         mprev = int'(len_sel);
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model (R4 stepping, R5/R6 pulses)
   always @(negedge clk) begin
      if (cycles > 2) begin
         chk("R4 model count", int'(count_o), mcnt);
         chk("R5 model carry", int'(carry_o), mcar);
         chk("R6 model borrow", int'(borrow_o), mbor);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected=<200000", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic tick(logic r, logic f, logic [3:0] s);
      @(negedge clk);
      ref_i = r; fb_i = f; len_sel = s;
      @(posedge clk);
      #1;
      if (carry_o)  ncar++;
      if (borrow_o) nbor++;
   endtask

   initial begin
      repeat (3) tick(0, 0, 0);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 count", int'(count_o), 0);
      chk("R1 carry", int'(carry_o), 0);
      chk("R1 borrow", int'(borrow_o), 0);

      // Modulus 8: the code change edge trims only, then counts up to wrap
      tick(0, 0, 1);
      chk("R7 first edge count", int'(count_o), 0);
      repeat (7) tick(0, 0, 1);
      chk("R2 top of mod 8", int'(count_o), 7);
      tick(0, 0, 1);
      chk("R5 wrap count", int'(count_o), 0);
      chk("R5 carry", int'(carry_o), 1);
      tick(0, 0, 1);
      chk("R5 carry one clock", int'(carry_o), 0);
      chk("R5 count after wrap", int'(count_o), 1);
      ncar = 0;
      repeat (16) tick(0, 0, 1);
      chk("R2 carries in 16 steps mod 8", ncar, 2);
      chk("R2 count after 16", int'(count_o), 1);

      // R4: every detector input combination
      tick(1, 0, 1);
      chk("R4 10 counts down", int'(count_o), 0);
      tick(0, 1, 1);
      chk("R6 borrow top", int'(count_o), 7);
      chk("R6 borrow", int'(borrow_o), 1);
      tick(1, 1, 1);
      chk("R4 11 counts up", int'(count_o), 0);
      chk("R4 11 carry", int'(carry_o), 1);
      chk("R6 no borrow with carry", int'(borrow_o), 0);

      // R3: disabled counter ignores the detector
      ncar = 0; nbor = 0;
      for (int i = 0; i < 20; i++) tick(i[0], i[1], 0);
      chk("R3 count held", int'(count_o), 0);
      chk("R3 no pulses", ncar + nbor, 0);

      // R7: shorten while the trimmed count sits on the new top
      tick(0, 0, 3);
      repeat (31) tick(0, 0, 3);
      chk("R2 top of mod 32", int'(count_o), 31);
      ncar = 0;
      tick(0, 0, 1);
      chk("R7 trimmed count", int'(count_o), 7);
      chk("R7 no carry on change", ncar, 0);
      tick(0, 0, 1);
      chk("R7 then wraps", int'(carry_o), 1);
      repeat (7) tick(0, 0, 1);
      tick(0, 0, 2);
      chk("R7 lengthen keeps count", int'(count_o), 7);

      // Longest counter: borrow gives 131071
      tick(1, 0, 15);
      chk("R7 change to 15", int'(count_o), 7);
      repeat (7) tick(1, 0, 15);
      chk("R4 down to 0", int'(count_o), 0);
      tick(1, 0, 15);
      chk("R2 top of mod 131072", int'(count_o), 131071);
      chk("R6 borrow mod 131072", int'(borrow_o), 1);
      tick(0, 0, 15);
      chk("R5 carry mod 131072", int'(carry_o), 1);

      // Modulus 128: one full lap gives one carry
      tick(0, 0, 5);
      ncar = 0;
      repeat (128) tick(0, 0, 5);
      chk("R2 carries per lap mod 128", ncar, 1);
      chk("R2 lap returns to 0", int'(count_o), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule